// File: doc/BRIEF.md
# Redundant Clock Role and Fallback Selector

This block holds the clock-source control for one board in a timing network that spans several chassis. Two redundant inter-chassis clock lines, left and right, carry system timing. A shared 8 kHz reference line feeds the board that leads. A configured role decides whether the board drives one of the two lines, and from which source. Primary master locks to the 8 kHz reference line. Local-primary locks to the backplane frame clock. Secondary master runs from its own oscillator. A slave drives no line and recovers timing from a line.

Four 8 kHz inputs are watched against an internal 8 kHz tick, counted on the fast system clock. These are the reference line, the backplane frame clock, and the left and right lines. Each input gets a live loss indication and a sticky loss flag. A slave with fallback enabled moves to the backup line when its primary line is lost, and it stays there until software pulses a re-arm. Configuration is shadowed and applied only on a tick, so a role or line change never cuts a clock pulse short. The block's interface is control and status only: every pin is a plain level or pulse, with no streaming handshake.

Top module: `clk_role_sel`

## Requirements
- R1: After reset the applied configuration is slave with every field zero. Both line enables are 0 and `src_sel` is 2. All loss flags, `fb_flag` and `cfg_err` are 0, `bp_master_en` is 1 and `ref_copy_en` is 0.
- R2: Configuration inputs take effect only in the cycle after a system clock edge where `tick_8k` is high. Between ticks, the outputs derived from the configuration do not change.
- R3: Role encoding: 0 slave, 1 primary, 2 secondary, 3 local-primary. Line encoding: 0 left, 1 right. `line_oe` bit 0 is left and bit 1 is right. As primary, the board drives only the line named by `cfg_line`, and `src_sel` is 0 (reference line).
- R4: As secondary, the board drives `cfg_line` and `src_sel` is 4 (internal oscillator), provided `cfg_line` differs from `cfg_prim_line`. If the two are equal, `line_oe` is 0 and `cfg_err` is 1.
- R5: As slave, `line_oe` is 0 and `src_sel` is 2 (the line named by `cfg_prim_line`), unless a fallback is in force.
- R6: Loss bit order is 0 reference line, 1 backplane frame, 2 left, 3 right. An input is declared lost after 4 consecutive tick periods with no rising edge. At that point both its `loss_now` bit and its `loss_sticky` bit go to 1.
- R7: A lost input returns to `loss_now` 0 after 16 consecutive tick periods that each hold a rising edge. Its sticky bit stays 1.
- R8: A slave with `cfg_fb_en` 1 whose primary line is lost switches `src_sel` to 3 (backup line) and sets `fb_flag`. It stays there after the primary recovers. With `cfg_fb_en` 0, a loss does not change `src_sel`.
- R9: A one-cycle `rearm` pulse clears `fb_flag` and every sticky loss bit. If the primary line is still lost, the fallback is taken again on the next cycle.
- R10: In local-primary mode the board drives `cfg_line`, `src_sel` is 1 (backplane frame clock) and `bp_master_en` is 0. In every other role `bp_master_en` is 1.
- R11: `ref_copy_en` follows the applied `cfg_bridge` bit. This bit enables copying the backplane secondary reference onto the reference line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_8k | input | 1 | One-cycle internal 8 kHz frame tick |
| ref8k_in | input | 1 | Inter-chassis 8 kHz reference line (asynchronous) |
| bpframe_in | input | 1 | Local backplane frame clock (asynchronous) |
| left_in | input | 1 | Left inter-chassis clock line as received |
| right_in | input | 1 | Right inter-chassis clock line as received |
| cfg_role | input | 2 | Requested role |
| cfg_line | input | 1 | Line this board drives (0 left, 1 right) |
| cfg_prim_line | input | 1 | Line driven by the system primary |
| cfg_fb_en | input | 1 | Enables automatic fallback in slave role |
| cfg_bridge | input | 1 | Requests copying of the backplane reference onto the reference line |
| rearm | input | 1 | Pulse: clear fallback and sticky flags |
| line_oe | output | 2 | Drive enables, bit 0 left, bit 1 right |
| ref_copy_en | output | 1 | Reference-line copy enable |
| bp_master_en | output | 1 | Board masters the local backplane clocks |
| src_sel | output | 3 | Active timing source code |
| loss_now | output | 4 | Live loss state per watched input |
| loss_sticky | output | 4 | Sticky loss flags per watched input |
| fb_flag | output | 1 | Fallback has occurred and is in force |
| cfg_err | output | 1 | Secondary line choice collides with primary |

## Verification
The functions most likely to meet in one cycle are a software re-arm and a loss that is still present on the primary line. The bench holds the left line silent until the slave falls back, then pulses `rearm` while the loss persists. It expects the sticky left bit to remain cleared. It also expects `fb_flag` and the backup source to reappear within two cycles, because the fallback must be retaken. Loss and recovery are also timed to the exact tick: the flags are sampled one tick before and one tick after the declared threshold.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [1:0] {
    ROLE_SLAVE   = 2'd0,
    ROLE_PRIMARY = 2'd1,
    ROLE_SECOND  = 2'd2,
    ROLE_PRIM_BP = 2'd3
  } role_e;

  typedef enum logic [2:0] {
    SRC_REF8K  = 3'd0,
    SRC_BPFRM  = 3'd1,
    SRC_PRIML  = 3'd2,
    SRC_BKUPL  = 3'd3,
    SRC_OSC    = 3'd4
  } src_e;

  typedef struct packed {
    role_e role;
    logic  line;
    logic  prim_line;
    logic  fb_en;
    logic  bridge;
  } cfg_t;

  localparam int MON_REF   = 0;
  localparam int MON_BPFRM = 1;
  localparam int MON_LEFT  = 2;
  localparam int MON_RIGHT = 3;
  localparam int N_MON     = 4;
endpackage

// File: rtl/crs_clk_mon.sv
module crs_clk_mon #(
  parameter int LOSS_TICKS  = 4,
  parameter int GOOD_TICKS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clk_in,
  input  logic rearm,
  output logic lost,
  output logic sticky
);
  localparam int MW = $clog2(LOSS_TICKS + 1);
  localparam int GW = $clog2(GOOD_TICKS + 1);

  logic [SYNC_STAGES:0] sh_q;
  logic                 rise, seen_q, seen;
  logic [MW-1:0]        miss_q;
  logic [GW-1:0]        good_q;
  logic                 lost_q, sticky_q;
  logic                 lost_set, lost_clr;

  assign rise     = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign seen     = seen_q | rise;
  assign lost_set = tick & ~seen & ~lost_q & (miss_q == MW'(LOSS_TICKS - 1));
  assign lost_clr = tick & seen & lost_q & (good_q == GW'(GOOD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q     <= '0;
      seen_q   <= 1'b0;
      miss_q   <= '0;
      good_q   <= '0;
      lost_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      sh_q     <= {sh_q[SYNC_STAGES-1:0], clk_in};
      sticky_q <= (sticky_q & ~rearm) | lost_set;
      if (tick) begin
        seen_q <= 1'b0;
        if (seen) begin
          miss_q <= '0;
          if (lost_clr) begin
            lost_q <= 1'b0;
            good_q <= '0;
          end else if (lost_q) begin
            good_q <= good_q + 1'b1;
          end
        end else begin
          good_q <= '0;
          if (lost_set) begin
            lost_q <= 1'b1;
            miss_q <= '0;
          end else if (!lost_q) begin
            miss_q <= miss_q + 1'b1;
          end
        end
      end else if (rise) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign lost   = lost_q;
  assign sticky = sticky_q;

  // R6: loss is only declared on a frame tick and always marks the sticky flag
  assert_loss_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> ($past(tick) && sticky_q));

  // R7: recovery is only declared on a frame tick
  assert_recover_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost_q) |-> $past(tick));
endmodule

// File: rtl/crs_cfg_shadow.sv
module crs_cfg_shadow
  import crs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  cfg_t cfg_in,
  output cfg_t cfg_act
);
  cfg_t act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '{role: ROLE_SLAVE, line: 1'b0, prim_line: 1'b0, fb_en: 1'b0, bridge: 1'b0};
    end else if (tick) begin
      act_q <= cfg_in;
    end
  end

  assign cfg_act = act_q;

  // R2: applied configuration moves only at a frame boundary
  assert_cfg_at_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(act_q));
endmodule

// File: rtl/crs_role_ctrl.sv
module crs_role_ctrl
  import crs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cfg_t       cfg_act,
  input  logic       lost_left,
  input  logic       lost_right,
  input  logic       rearm,
  output logic [1:0] line_oe,
  output src_e       src_sel,
  output logic       fb_flag,
  output logic       cfg_err,
  output logic       bp_master_en,
  output logic       ref_copy_en
);
  logic fell_q, prim_lost, is_slave;

  assign is_slave  = (cfg_act.role == ROLE_SLAVE);
  assign prim_lost = cfg_act.prim_line ? lost_right : lost_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fell_q <= 1'b0;
    end else if (rearm || !is_slave) begin
      fell_q <= 1'b0;
    end else if (cfg_act.fb_en && prim_lost) begin
      fell_q <= 1'b1;
    end
  end

  always_comb begin
    line_oe = 2'b00;
    cfg_err = 1'b0;
    src_sel = SRC_PRIML;
    unique case (cfg_act.role)
      ROLE_PRIMARY: begin
        line_oe[cfg_act.line] = 1'b1;
        src_sel = SRC_REF8K;
      end
      ROLE_PRIM_BP: begin
        line_oe[cfg_act.line] = 1'b1;
        src_sel = SRC_BPFRM;
      end
      ROLE_SECOND: begin
        src_sel = SRC_OSC;
        if (cfg_act.line == cfg_act.prim_line) cfg_err = 1'b1;
        else line_oe[cfg_act.line] = 1'b1;
      end
      default: begin
        src_sel = fell_q ? SRC_BKUPL : SRC_PRIML;
      end
    endcase
  end

  assign fb_flag      = fell_q;
  assign bp_master_en = (cfg_act.role != ROLE_PRIM_BP);
  assign ref_copy_en  = cfg_act.bridge;

  // R8: fallback is non-revertive while the role stays slave and no re-arm comes
  assert_fallback_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fell_q && is_slave && !rearm) |=> fell_q);

  // R5: a slave never drives an inter-chassis line
  assert_slave_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_slave |-> (line_oe == 2'b00));

  // R4: a line collision leaves both lines undriven
  assert_conflict_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (line_oe == 2'b00 && cfg_act.role == ROLE_SECOND));
endmodule

// File: rtl/clk_role_sel.sv
module clk_role_sel
  import crs_pkg::*;
#(
  parameter int LOSS_TICKS  = 4,
  parameter int GOOD_TICKS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_8k,
  input  logic       ref8k_in,
  input  logic       bpframe_in,
  input  logic       left_in,
  input  logic       right_in,
  input  logic [1:0] cfg_role,
  input  logic       cfg_line,
  input  logic       cfg_prim_line,
  input  logic       cfg_fb_en,
  input  logic       cfg_bridge,
  input  logic       rearm,
  output logic [1:0] line_oe,
  output logic       ref_copy_en,
  output logic       bp_master_en,
  output logic [2:0] src_sel,
  output logic [3:0] loss_now,
  output logic [3:0] loss_sticky,
  output logic       fb_flag,
  output logic       cfg_err
);
  logic [N_MON-1:0] mon_in;
  cfg_t             cfg_req, cfg_act;
  src_e             src_int;

  assign mon_in[MON_REF]   = ref8k_in;
  assign mon_in[MON_BPFRM] = bpframe_in;
  assign mon_in[MON_LEFT]  = left_in;
  assign mon_in[MON_RIGHT] = right_in;

  for (genvar i = 0; i < N_MON; i++) begin : g_mon
    crs_clk_mon #(
      .LOSS_TICKS (LOSS_TICKS),
      .GOOD_TICKS (GOOD_TICKS),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_8k),
      .clk_in(mon_in[i]),
      .rearm (rearm),
      .lost  (loss_now[i]),
      .sticky(loss_sticky[i])
    );
  end

  assign cfg_req = '{role: role_e'(cfg_role), line: cfg_line, prim_line: cfg_prim_line,
                     fb_en: cfg_fb_en, bridge: cfg_bridge};

  crs_cfg_shadow u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_8k),
    .cfg_in (cfg_req),
    .cfg_act(cfg_act)
  );

  crs_role_ctrl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_act     (cfg_act),
    .lost_left   (loss_now[MON_LEFT]),
    .lost_right  (loss_now[MON_RIGHT]),
    .rearm       (rearm),
    .line_oe     (line_oe),
    .src_sel     (src_int),
    .fb_flag     (fb_flag),
    .cfg_err     (cfg_err),
    .bp_master_en(bp_master_en),
    .ref_copy_en (ref_copy_en)
  );

  assign src_sel = src_int;

  // R3: at most one line is ever driven by this board
  assert_single_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe != 2'b11);
endmodule

// File: tb/sim_clk_role_sel.sv
module sim_clk_role_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_8k = 1'b0;
  logic [3:0] ck_en = 4'b1111;
  logic [3:0] ck = 4'b0000;
  logic [1:0] cfg_role = 2'd0;
  logic       cfg_line = 1'b0, cfg_prim_line = 1'b0, cfg_fb_en = 1'b0, cfg_bridge = 1'b0;
  logic       rearm = 1'b0;
  logic [1:0] line_oe;
  logic       ref_copy_en, bp_master_en, fb_flag, cfg_err;
  logic [2:0] src_sel;
  logic [3:0] loss_now, loss_sticky;
  int         n_run = 0, n_fail = 0;
  int         tcnt = 0;
  int         ccnt [4] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  clk_role_sel u0 (
    .clk(clk), .rst_n(rst_n), .tick_8k(tick_8k),
    .ref8k_in(ck[0]), .bpframe_in(ck[1]), .left_in(ck[2]), .right_in(ck[3]),
    .cfg_role(cfg_role), .cfg_line(cfg_line), .cfg_prim_line(cfg_prim_line),
    .cfg_fb_en(cfg_fb_en), .cfg_bridge(cfg_bridge), .rearm(rearm),
    .line_oe(line_oe), .ref_copy_en(ref_copy_en), .bp_master_en(bp_master_en),
    .src_sel(src_sel), .loss_now(loss_now), .loss_sticky(loss_sticky),
    .fb_flag(fb_flag), .cfg_err(cfg_err)
  );

  // internal frame tick: one cycle in twenty
  always @(negedge clk) begin
    tcnt    <= (tcnt == 19) ? 0 : tcnt + 1;
    tick_8k <= (tcnt == 19);
  end

  // watched 8 kHz-like inputs, period ten cycles, gated per input
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!ck_en[i]) begin
        ck[i]   <= 1'b0;
        ccnt[i] <= 0;
      end else begin
        ck[i]   <= (ccnt[i] < 5);
        ccnt[i] <= (ccnt[i] == 9) ? 0 : ccnt[i] + 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      do @(posedge clk); while (!tick_8k);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic apply_cfg(input logic [1:0] r, input logic ln, input logic pl,
                           input logic fb, input logic br);
    cfg_role = r; cfg_line = ln; cfg_prim_line = pl; cfg_fb_en = fb; cfg_bridge = br;
    wait_ticks(1);
  endtask

  // stop input idx in mid-period; returns right after the tick that closes the last edge period
  task automatic stop_line(input int idx);
    wait_ticks(1);
    repeat (8) @(negedge clk);
    ck_en[idx] = 1'b0;
    wait_ticks(1);
  endtask

  task automatic start_line(input int idx);
    wait_ticks(1);
    repeat (8) @(negedge clk);
    ck_en[idx] = 1'b1;
    wait_ticks(1);
  endtask

  task automatic pulse_rearm();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 line_oe", line_oe, 0);
    chk("R1 src_sel", src_sel, 2);
    chk("R1 loss_now", loss_now, 0);
    chk("R1 loss_sticky", loss_sticky, 0);
    chk("R1 fb_flag", fb_flag, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 bp_master_en", bp_master_en, 1);
    chk("R1 ref_copy_en", ref_copy_en, 0);
  endtask

  task automatic t_frame_apply();
    wait_ticks(1);
    repeat (5) @(negedge clk);
    cfg_role = 2'd1; cfg_line = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 held before tick", line_oe, 0);
    wait_ticks(1);
    chk("R2 R3 primary right", line_oe, 2'b10);
    chk("R3 primary source", src_sel, 0);
    apply_cfg(2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 primary left", line_oe, 2'b01);
  endtask

  task automatic t_secondary();
    apply_cfg(2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4 secondary drives right", line_oe, 2'b10);
    chk("R4 secondary source", src_sel, 4);
    chk("R4 no error", cfg_err, 0);
    apply_cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 collision off", line_oe, 0);
    chk("R4 collision flag", cfg_err, 1);
  endtask

  task automatic t_local_primary();
    apply_cfg(2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 local drives left", line_oe, 2'b01);
    chk("R10 local source", src_sel, 1);
    chk("R10 backplane not mastered", bp_master_en, 0);
    apply_cfg(2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 backplane mastered again", bp_master_en, 1);
  endtask

  task automatic t_bridge();
    apply_cfg(2'd1, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R11 copy enabled", ref_copy_en, 1);
    apply_cfg(2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R11 copy disabled", ref_copy_en, 0);
  endtask

  task automatic t_slave();
    apply_cfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 slave quiet", line_oe, 0);
    chk("R5 slave source", src_sel, 2);
  endtask

  task automatic t_loss_recover();
    stop_line(0);
    wait_ticks(3);
    chk("R6 not lost after 3 empty", loss_now[0], 0);
    wait_ticks(1);
    chk("R6 lost after 4 empty", loss_now[0], 1);
    chk("R6 sticky set", loss_sticky[0], 1);
    chk("R6 other inputs clean", loss_now[3:1], 0);
    start_line(0);
    wait_ticks(14);
    chk("R7 still lost at 15 good", loss_now[0], 1);
    wait_ticks(1);
    chk("R7 recovered at 16 good", loss_now[0], 0);
    chk("R7 sticky kept", loss_sticky[0], 1);
    pulse_rearm();
    chk("R9 sticky cleared", loss_sticky[0], 0);
  endtask

  task automatic t_no_fallback();
    apply_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    stop_line(2);
    wait_ticks(5);
    chk("R8 loss seen on left", loss_now[2], 1);
    chk("R8 no switch when disabled", src_sel, 2);
    chk("R8 no fallback flag", fb_flag, 0);
    start_line(2);
    wait_ticks(17);
    chk("R7 left recovered", loss_now[2], 0);
    pulse_rearm();
  endtask

  task automatic t_fallback();
    apply_cfg(2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    stop_line(2);
    wait_ticks(5);
    chk("R8 switched to backup", src_sel, 3);
    chk("R8 fallback flag", fb_flag, 1);
    start_line(2);
    wait_ticks(17);
    chk("R8 primary recovered", loss_now[2], 0);
    chk("R8 non-revertive", src_sel, 3);
    pulse_rearm();
    chk("R9 back on primary", src_sel, 2);
    chk("R9 flag cleared", fb_flag, 0);
    chk("R9 sticky left cleared", loss_sticky[2], 0);
  endtask

  task automatic t_rearm_collide();
    stop_line(2);
    wait_ticks(5);
    chk("R8 fallback again", fb_flag, 1);
    pulse_rearm();
    @(negedge clk);
    chk("R9 retaken while lost", fb_flag, 1);
    chk("R9 backup while lost", src_sel, 3);
    chk("R9 sticky stays cleared", loss_sticky[2], 0);
    start_line(2);
    wait_ticks(17);
    pulse_rearm();
    chk("R9 final primary", src_sel, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame_apply();
    t_secondary();
    t_local_primary();
    t_bridge();
    t_slave();
    t_loss_recover();
    t_no_fallback();
    t_fallback();
    t_rearm_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule